// File: doc/BRIEF.md
# Boot Window Command Decoder

This block watches host writes to a flash interface and acts on the ones that fall inside the boot buffer window. The window covers word offsets 0x0000 to 0x01FF and 0x8000 to 0x800F. Three command values are understood there:

- A reset value raises a one-cycle warm-reset request.
- A two-write sequence raises a one-cycle page-load request. It carries the linear sector number of the page and a count of one full page of sectors.
- An identification value makes the block write three words at the start of the boot buffer.

The block also holds the eight start address registers at offsets 0xF100 to 0xF107 and the start-buffer register at offset 0xF200. It derives the sector number from the block register (0xF100) and the page register (0xF107). The page register steps forward by one page after every two-write load, so a host can read consecutive pages with repeated load sequences. The array read and the rest of the buffer RAM are outside the block. It only issues the requests and the identification writes.

Top module: `boot_cmd_decoder`

## Requirements
- R1: After reset all request outputs and `id_we` are low, `buf_index` is 0, `sect_count` is 1, and every start address register is 0.
- R2: A boot-window write of 0x00F0 (when not armed) pulses `reset_req` for one cycle. It clears all start address registers, sets `buf_index` to 0 and sets `sect_count` to 1.
- R3: A boot-window write of 0x00E0 arms the block. If the next boot-window write carries 0x0000, `load_req` pulses for one cycle with `load_sector` and with `load_count` equal to 4.
- R4: While armed, the next boot-window write always disarms, whatever its value. A value other than 0x0000 then produces no request and no unknown flag, and 0x00F0 in that position causes no reset.
- R5: Each two-write load replaces the page register (0xF107) with its old value plus 4, keeping only bits 7:0, so 0xFC wraps to 0x00.
- R6: `load_sector` is {blk, page[7:0]}, where blk is block register bits 11:0, ORed with `density_mask` when block register bit 15 is 1. This equals page[1:0] + 4 * (page[7:2] + 64 * blk).
- R7: A boot-window write of 0x0090 produces three `id_we` cycles, one per cycle, with `id_addr` 0, 1 and 2. Their `id_data` values are the low bytes of `man_id`, `dev_id` and `wp_status`, zero-extended.
- R8: A write to 0xF200 sets `buf_index` from data bits 11:8 and `sect_count` from bits 1:0, where a field value of 0 means 4.
- R9: Any other boot-window value, written while not armed, pulses `unknown_cmd` for one cycle and changes no state.
- R10: Writes at addresses outside the window and outside the register offsets have no effect. 0x8010 and 0x0200 lie outside the window.
- R11: Offsets 0x8000 to 0x800F accept the same commands as offsets 0x0000 to 0x01FF, and the two ranges can be mixed within one two-write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 16 | Host word offset |
| wr_data | input | 16 | Host write value |
| density_mask | input | 12 | Value ORed into the block number when block bit 15 is set |
| man_id | input | 16 | Manufacturer identifier |
| dev_id | input | 16 | Device identifier |
| wp_status | input | 16 | Write-protection status word |
| load_req | output | 1 | One-cycle page-load request |
| load_sector | output | 20 | First sector of the page to load |
| load_count | output | 3 | Sectors per load (one page) |
| reset_req | output | 1 | One-cycle warm-reset request |
| unknown_cmd | output | 1 | One-cycle flag for an unrecognised boot-window value |
| id_we | output | 1 | Identification word write strobe |
| id_addr | output | 2 | Boot buffer word index for the identification write |
| id_data | output | 16 | Identification word value |
| buf_index | output | 4 | Buffer index from the start-buffer register |
| sect_count | output | 3 | Sector count from the start-buffer register |

## Verification
- The load, reset and unknown-command pulses appear in the first cycle after the write that completes the command.
- The identification words follow on the first, second and third cycles after the 0x0090 write.
- Register writes change `buf_index`, `sect_count` and the next sector number from the cycle after the write.

The bench records the cycle in which it presents each write. It queues every expected event with the exact cycle it is due and its data. A monitor samples on the falling edge and flags any event that arrives early, late, in the wrong form or unannounced. Register state is read only after the capturing edge has passed.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;

  localparam int ADDR_W = 16;

  // command values understood inside the boot window
  localparam logic [15:0] CMD_RESET    = 16'h00F0;
  localparam logic [15:0] CMD_LOAD     = 16'h00E0;
  localparam logic [15:0] CMD_IDENT    = 16'h0090;
  localparam logic [15:0] LOAD_CONFIRM = 16'h0000;

  // window limits and register offsets
  localparam logic [ADDR_W-1:0] WIN_LO_END  = 16'h01FF;
  localparam logic [ADDR_W-1:0] WIN_HI_BASE = 16'h8000;
  localparam logic [ADDR_W-1:0] WIN_HI_END  = 16'h800F;
  localparam logic [ADDR_W-1:0] START_BASE  = 16'hF100;
  localparam logic [ADDR_W-1:0] BUFSEL_ADDR = 16'hF200;

  localparam int ID_WORDS = 3;

  typedef struct packed {
    logic do_reset;
    logic do_load;
    logic do_ident;
    logic bad_cmd;
  } boot_act_t;

  function automatic logic in_boot_window(input logic [ADDR_W-1:0] a);
    return (a <= WIN_LO_END) || ((a >= WIN_HI_BASE) && (a <= WIN_HI_END));
  endfunction

endpackage

// File: rtl/boot_cmd_fsm.sv
module boot_cmd_fsm
  import boot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output boot_act_t           act
);

  logic armed_q, armed_d;
  logic win_hit;

  assign win_hit = wr_en && in_boot_window(wr_addr);

  always_comb begin
    armed_d = armed_q;
    act     = '0;
    if (win_hit) begin
      if (armed_q) begin
        // second cycle: always disarm, act only on the confirm value
        armed_d     = 1'b0;
        act.do_load = (wr_data == DATA_W'(LOAD_CONFIRM));
      end else begin
        unique case (wr_data)
          DATA_W'(CMD_RESET): act.do_reset = 1'b1;
          DATA_W'(CMD_LOAD):  armed_d      = 1'b1;
          DATA_W'(CMD_IDENT): act.do_ident = 1'b1;
          default:            act.bad_cmd  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

endmodule

// File: rtl/boot_addr_regs.sv
module boot_addr_regs
  import boot_cmd_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int NUM_REGS      = 8,
  parameter int BLK_REG       = 0,
  parameter int PAGE_REG      = 7,
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 8,
  parameter int SECT_PER_PAGE = 4,
  parameter int IDX_W         = 4,
  localparam int SECT_W       = BLK_W + PAGE_W,
  localparam int FLD_W        = $clog2(SECT_PER_PAGE),
  localparam int CNT_W        = FLD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              advance,
  input  logic [BLK_W-1:0]  density_mask,
  output logic [SECT_W-1:0] sector,
  output logic [IDX_W-1:0]  buf_index,
  output logic [CNT_W-1:0]  sect_count
);

  logic [DATA_W-1:0] start_q [NUM_REGS];
  logic [DATA_W-1:0] page_adv;
  logic [BLK_W-1:0]  blk_val;

  // next page: step by one page, upper bits dropped
  assign page_adv = DATA_W'(start_q[PAGE_REG][PAGE_W-1:0] + PAGE_W'(SECT_PER_PAGE));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_start
    logic              we;
    logic [DATA_W-1:0] nxt;
    assign we = wr_en && (wr_addr == START_BASE + ADDR_W'(g));
    always_comb begin
      nxt = start_q[g];
      if (clr)                          nxt = '0;
      else if (advance && g == PAGE_REG) nxt = page_adv;
      else if (we)                      nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q[g] <= '0;
      else        start_q[g] <= nxt;
    end
  end

  assign blk_val = start_q[BLK_REG][BLK_W-1:0]
                 | (start_q[BLK_REG][DATA_W-1] ? density_mask : '0);
  assign sector  = {blk_val, start_q[PAGE_REG][PAGE_W-1:0]};

  // start-buffer register
  logic             bsel_we;
  logic [IDX_W-1:0] idx_d;
  logic [CNT_W-1:0] cnt_d;

  assign bsel_we = wr_en && (wr_addr == BUFSEL_ADDR);

  always_comb begin
    idx_d = buf_index;
    cnt_d = sect_count;
    if (clr) begin
      idx_d = '0;
      cnt_d = CNT_W'(1);
    end else if (bsel_we) begin
      idx_d = wr_data[8 +: IDX_W];
      cnt_d = (wr_data[FLD_W-1:0] == '0) ? CNT_W'(SECT_PER_PAGE)
                                         : CNT_W'(wr_data[FLD_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_index  <= '0;
      sect_count <= CNT_W'(1);
    end else begin
      buf_index  <= idx_d;
      sect_count <= cnt_d;
    end
  end

endmodule

// File: rtl/boot_id_seq.sv
module boot_id_seq
  import boot_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int PH_W  = $clog2(ID_WORDS + 1),
  localparam int IA_W  = $clog2(ID_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] man_id,
  input  logic [DATA_W-1:0] dev_id,
  input  logic [DATA_W-1:0] wp_status,
  output logic              id_we,
  output logic [IA_W-1:0]   id_addr,
  output logic [DATA_W-1:0] id_data
);

  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (start)                               phase_d = PH_W'(1);
    else if (phase_q == PH_W'(ID_WORDS))      phase_d = '0;
    else if (phase_q != '0)                   phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign id_we   = (phase_q != '0);
  assign id_addr = IA_W'(phase_q - PH_W'(1));

  always_comb begin
    id_data = '0;
    unique case (phase_q)
      PH_W'(1): id_data = DATA_W'(man_id[7:0]);
      PH_W'(2): id_data = DATA_W'(dev_id[7:0]);
      PH_W'(3): id_data = DATA_W'(wp_status[7:0]);
      default:  id_data = '0;
    endcase
  end

endmodule

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 8,
  parameter int SECT_PER_PAGE = 4,
  parameter int IDX_W         = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [15:0]                            wr_addr,
  input  logic [DATA_W-1:0]                      wr_data,
  input  logic [BLK_W-1:0]                       density_mask,
  input  logic [DATA_W-1:0]                      man_id,
  input  logic [DATA_W-1:0]                      dev_id,
  input  logic [DATA_W-1:0]                      wp_status,
  output logic                                   load_req,
  output logic [BLK_W+PAGE_W-1:0]                load_sector,
  output logic [$clog2(SECT_PER_PAGE):0]         load_count,
  output logic                                   reset_req,
  output logic                                   unknown_cmd,
  output logic                                   id_we,
  output logic [1:0]                             id_addr,
  output logic [DATA_W-1:0]                      id_data,
  output logic [IDX_W-1:0]                       buf_index,
  output logic [$clog2(SECT_PER_PAGE):0]         sect_count
);

  localparam int SECT_W = BLK_W + PAGE_W;
  localparam int CNT_W  = $clog2(SECT_PER_PAGE) + 1;

  boot_act_t         act;
  logic [SECT_W-1:0] cur_sector;

  boot_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .act     (act)
  );

  boot_addr_regs #(
    .DATA_W        (DATA_W),
    .BLK_W         (BLK_W),
    .PAGE_W        (PAGE_W),
    .SECT_PER_PAGE (SECT_PER_PAGE),
    .IDX_W         (IDX_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .clr          (act.do_reset),
    .advance      (act.do_load),
    .density_mask (density_mask),
    .sector       (cur_sector),
    .buf_index    (buf_index),
    .sect_count   (sect_count)
  );

  boot_id_seq #(.DATA_W(DATA_W)) u_id (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (act.do_ident),
    .man_id    (man_id),
    .dev_id    (dev_id),
    .wp_status (wp_status),
    .id_we     (id_we),
    .id_addr   (id_addr),
    .id_data   (id_data)
  );

  // registered request outputs
  logic              load_req_d, reset_req_d, unknown_d;
  logic [SECT_W-1:0] sector_d;

  always_comb begin
    load_req_d  = act.do_load;
    reset_req_d = act.do_reset;
    unknown_d   = act.bad_cmd;
    sector_d    = load_sector;
    if (act.do_load) sector_d = cur_sector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_req    <= 1'b0;
      reset_req   <= 1'b0;
      unknown_cmd <= 1'b0;
      load_sector <= '0;
    end else begin
      load_req    <= load_req_d;
      reset_req   <= reset_req_d;
      unknown_cmd <= unknown_d;
      load_sector <= sector_d;
    end
  end

  assign load_count = CNT_W'(SECT_PER_PAGE);

endmodule

// File: rtl/boot_cmd_checker.sv
module boot_cmd_checker
  import boot_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [15:0] wr_data,
  input logic        load_req,
  input logic [2:0]  load_count,
  input logic        reset_req,
  input logic        unknown_cmd,
  input logic        id_we,
  input logic [1:0]  id_addr,
  input logic [2:0]  sect_count
);

  logic win;
  assign win = wr_en && in_boot_window(wr_addr);

  // R3: a load request follows a boot-window confirm write and carries a full page
  p_load_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> ($past(win) && $past(wr_data) == 16'h0000 && load_count == 3'd4));

  // R3: two loads can never come in adjacent cycles (two writes each)
  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  // R2: a reset request follows a boot-window reset value
  p_reset_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(win) && $past(wr_data) == 16'h00F0));

  // R9: the unknown flag follows a boot-window write of another value
  p_unknown_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_cmd |-> ($past(win) && $past(wr_data) != 16'h00E0 && $past(wr_data) != 16'h0090));

  // R9: at most one request kind per cycle
  p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_req, reset_req, unknown_cmd}));

  // R7: identification words are written in order 0, 1, 2
  p_id_order1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_we && id_addr == 2'd1) |-> $past(id_we && id_addr == 2'd0));
  p_id_order2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_we && id_addr == 2'd2) |-> $past(id_we && id_addr == 2'd1));
  p_id_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_we |-> id_addr != 2'd3);

  // R8: the sector count is always between 1 and 4
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sect_count != 3'd0 && sect_count <= 3'd4);

endmodule

bind boot_cmd_decoder boot_cmd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .load_req    (load_req),
  .load_count  (load_count),
  .reset_req   (reset_req),
  .unknown_cmd (unknown_cmd),
  .id_we       (id_we),
  .id_addr     (id_addr),
  .sect_count  (sect_count)
);

// File: tb/tb_boot_cmd_decoder.sv
`timescale 1ns/1ps
module tb_boot_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr, wr_data;
  logic [11:0] density_mask;
  logic [15:0] man_id, dev_id, wp_status;
  logic        load_req, reset_req, unknown_cmd, id_we;
  logic [19:0] load_sector;
  logic [2:0]  load_count, sect_count;
  logic [1:0]  id_addr;
  logic [15:0] id_data;
  logic [3:0]  buf_index;

  always #2.5 clk = ~clk;  // 200 MHz

  boot_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .density_mask(density_mask), .man_id(man_id), .dev_id(dev_id), .wp_status(wp_status),
    .load_req(load_req), .load_sector(load_sector), .load_count(load_count),
    .reset_req(reset_req), .unknown_cmd(unknown_cmd), .id_we(id_we), .id_addr(id_addr),
    .id_data(id_data), .buf_index(buf_index), .sect_count(sect_count)
  );

  typedef enum int {EV_LOAD, EV_RESET, EV_UNK, EV_ID} ev_kind_t;
  typedef struct {
    ev_kind_t kind;
    int       val;
    int       aux;
    int       due;
    string    req;
  } ev_t;

  ev_t q[$];
  int  cyc = 0;
  int  last_issue = 0;
  int  n_chk = 0, n_fail = 0;
  bit  mon_on = 0;
  bit  done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic bwr(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    last_issue = cyc;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_ev(input ev_kind_t k, input int v, input int x, input int dly, input string req);
    ev_t e;
    e.kind = k; e.val = v; e.aux = x; e.due = last_issue + dly; e.req = req;
    q.push_back(e);
  endtask

  task automatic expect_load(input int sector, input string req);
    expect_ev(EV_LOAD, sector, 4, 1, req);
  endtask

  task automatic match(input ev_kind_t k, input int v, input int x);
    ev_t e;
    if (q.size() == 0) begin
      check(1'b0, "unexpected event", int'(k), -1);
      return;
    end
    e = q.pop_front();
    check(e.kind == k && e.val == v && e.aux == x && e.due == cyc, e.req,
          (int'(k) << 28) | (cyc << 20) | v, (int'(e.kind) << 28) | (e.due << 20) | e.val);
  endtask

  // monitor: pops the scoreboard as events appear
  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].due < cyc) begin
        check(1'b0, {q[0].req, " missing event"}, 0, q[0].val);
        void'(q.pop_front());
      end
      if (load_req)    match(EV_LOAD, int'(load_sector), int'(load_count));
      if (reset_req)   match(EV_RESET, 0, 0);
      if (unknown_cmd) match(EV_UNK, 0, 0);
      if (id_we)       match(EV_ID, int'(id_data), int'(id_addr));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    density_mask = 12'h000; man_id = 16'hABEC; dev_id = 16'h5634; wp_status = 16'h7702;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!load_req && !reset_req && !unknown_cmd && !id_we, "R1 idle outputs",
          {load_req, reset_req, unknown_cmd, id_we}, 0);
    check(buf_index == 4'd0, "R1 buf_index", buf_index, 0);
    check(sect_count == 3'd1, "R1 sect_count", sect_count, 1);
    mon_on = 1;

    // R1: start registers are zero, so the first load reads sector 0
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load(0, "R1 zero sector");
    idle(2);

    // R3/R6: plain load
    bwr(16'hF100, 16'h0005); bwr(16'hF107, 16'h0009);
    bwr(16'h0000, 16'h00E0); bwr(16'h0100, 16'h0000); expect_load('h00509, "R3 R6 load");
    // R5: page steps by 4
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h0050D, "R5 advance");

    // R6: density mask with block bit 15, upper page bits ignored
    density_mask = 12'h400;
    bwr(16'hF100, 16'h8005); bwr(16'hF107, 16'h1234);
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h40534, "R6 density");
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h40538, "R5 mask to 8 bits");

    // R5: wrap at the top of the page field
    bwr(16'hF107, 16'h00FC);
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h405FC, "R5 before wrap");
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h40500, "R5 wrap");

    // R4: non-confirm second write disarms silently
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0001);
    bwr(16'h0000, 16'h0000); expect_ev(EV_UNK, 0, 0, 1, "R4 disarmed by other value");
    // R4: reset value while armed does nothing
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h00F0);
    bwr(16'h0000, 16'h0000); expect_ev(EV_UNK, 0, 0, 1, "R4 reset value while armed");

    // R11: upper window range, mixed with lower
    bwr(16'h800F, 16'h00E0); bwr(16'h8000, 16'h0000); expect_load('h40504, "R11 high window");

    // R10: outside addresses ignored
    bwr(16'h8010, 16'h00F0);
    bwr(16'h0200, 16'h0090);
    bwr(16'h4000, 16'h00E0);
    bwr(16'h0000, 16'h0000); expect_ev(EV_UNK, 0, 0, 1, "R10 outside writes ignored");
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h40508, "R10 page untouched");

    // R7: identification words
    bwr(16'h01FF, 16'h0090);
    expect_ev(EV_ID, 'h00EC, 0, 1, "R7 word 0");
    expect_ev(EV_ID, 'h0034, 1, 2, "R7 word 1");
    expect_ev(EV_ID, 'h0002, 2, 3, "R7 word 2");
    idle(5);

    // R8: start-buffer register
    bwr(16'hF200, 16'h0A03);
    check(buf_index == 4'hA, "R8 buf_index", buf_index, 'hA);
    check(sect_count == 3'd3, "R8 sect_count", sect_count, 3);
    bwr(16'hF200, 16'h0500);
    check(buf_index == 4'h5, "R8 buf_index zero field", buf_index, 5);
    check(sect_count == 3'd4, "R8 zero means 4", sect_count, 4);

    // R2: warm reset clears registers
    bwr(16'hF100, 16'h0003); bwr(16'hF107, 16'h0008);
    bwr(16'h0000, 16'h00F0); expect_ev(EV_RESET, 0, 0, 1, "R2 reset pulse");
    check(buf_index == 4'd0, "R2 buf_index cleared", buf_index, 0);
    check(sect_count == 3'd1, "R2 sect_count to 1", sect_count, 1);
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load(0, "R2 address cleared");

    // R9: unknown value, no state change
    bwr(16'h0010, 16'h1234); expect_ev(EV_UNK, 0, 0, 1, "R9 unknown flag");
    check(buf_index == 4'd0 && sect_count == 3'd1, "R9 state kept",
          {buf_index, sect_count}, 1);
    bwr(16'h0000, 16'h00E0); bwr(16'h0000, 16'h0000); expect_load('h00004, "R9 page kept");

    idle(5);
    check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    finish_run();
  end

endmodule